// File: doc/BRIEF.md
# Cache Maintenance Operation Sequencer

This block is the maintenance engine of a direct-mapped write-back data cache. Software-issued commands arrive on a valid/ready command port. Four commands are supported. Invalidate-all drops every line, and any dirty data in them is lost. Writeback-and-invalidate first copies every modified line to memory and then drops all lines. Flush-line cleans and drops one addressed line. A non-temporal store sends one word straight to memory without allocating a line. The line state array is held in small per-line register files. The sequencer walks that array through one sequential index, so it touches one line per cycle.

Dirty lines leave on a memory write port that uses a valid/ready handshake. When a whole-cache command ends, the block raises one or two notification pulses on a special bus cycle output so that caches further out can do the same. A single-cycle done pulse marks the end of every command. While a command runs, new commands and normal cache fills are held off. A probe port lets the surrounding cache, and the bench, look up any address without side effects.

Top module: `cmo_sequencer`

## Requirements
- R1: After reset every line reads as a miss on the probe port, `cmd_ready` and `acc_ready` are high, and `mem_valid`, `sbc_valid` and `done` are low.
- R2: Command code 2'b00 (invalidate-all) clears every line and issues no memory write. It then issues exactly one special cycle with code 2'b01 (invalidate). `done` rises LINES+2 cycles after the command is accepted.
- R3: Command code 2'b01 (writeback-and-invalidate) writes every valid dirty line to memory in ascending index order. Each write carries address {tag, index} and the line data. All writes come before the first special cycle, and afterwards every line is invalid.
- R4: After writeback-and-invalidate the special cycles depend on `sbc_two`. With `sbc_two`=0 there is a single cycle with code 2'b11 (combined). With `sbc_two`=1 there is code 2'b10 (writeback notice) and, in the next cycle, code 2'b01 (invalidate). The mode is taken when the command is accepted.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R6: With `wt_mode`=1, fills never mark a line dirty, so writeback-and-invalidate issues no memory write.
- R7: Command code 2'b10 (flush-line) on a present dirty line writes that line back once and then invalidates it. All other lines stay unchanged, and no special cycle is issued.
- R8: A flush-line that hits a clean line invalidates it without memory traffic. A flush-line that misses changes nothing, issues no memory write and no special cycle, and raises `done` 2 cycles after acceptance.
- R9: Command code 2'b11 (non-temporal store) writes `cmd_data` to `cmd_addr` on the memory port and allocates no line. If the address was cached, that line is invalid once the command completes. No special cycle is issued.
- R10: From acceptance until `done`, `cmd_ready` and `acc_ready` stay low. `done` is a one-cycle pulse that follows the final special cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_mode | input | 1 | Write-through mode: fills never set dirty |
| sbc_two | input | 1 | Selects two notification cycles after writeback-and-invalidate |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | ADDR_W | Word address for flush-line and non-temporal store |
| cmd_data | input | DATA_W | Store data for non-temporal store |
| acc_valid | input | 1 | Normal cache fill or write request |
| acc_ready | output | 1 | Normal access allowed (sequencer idle) |
| acc_addr | input | ADDR_W | Fill address |
| acc_data | input | DATA_W | Fill data |
| acc_dirty | input | 1 | Fill marks the line modified |
| probe_addr | input | ADDR_W | Lookup address |
| probe_hit | output | 1 | Probed address is cached |
| probe_dirty | output | 1 | Probed line is modified |
| probe_data | output | DATA_W | Data held in the probed slot |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Memory write word address |
| mem_data | output | DATA_W | Memory write data |
| sbc_valid | output | 1 | Special bus cycle pulse |
| sbc_code | output | 2 | Special cycle kind |
| done | output | 1 | Command complete pulse |

## Verification
Several rules are checked on every cycle by the assertions. These are the memory handshake hold, the ordering of the writeback notice before the invalidate notice, the single-cycle done that follows the last notice, and the silence of the memory port during invalidate-all. They also cover the quiet two-cycle completion of a flush miss, the rule that only dirty lines reach the memory port, and the single step per cycle of the scan index. Other results can only be shown by the bench's scenarios against its shadow copy of the cache: which lines get written back and in what order, whether a line is dropped or kept after a flush or a non-temporal store, the loss of dirty data on invalidate-all, and the absence of writebacks in write-through mode.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

   typedef enum logic [1:0] {
      OP_INV_ALL  = 2'b00,
      OP_WB_INV   = 2'b01,
      OP_FLUSH    = 2'b10,
      OP_NT_STORE = 2'b11
   } cmo_op_e;

   localparam logic [1:0] SBC_NONE  = 2'b00;
   localparam logic [1:0] SBC_INV   = 2'b01;
   localparam logic [1:0] SBC_WBN   = 2'b10;
   localparam logic [1:0] SBC_WBINV = 2'b11;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WB_SCAN,
      ST_WB_SEND,
      ST_INV_SCAN,
      ST_SBC_A,
      ST_SBC_B,
      ST_FL_LOOK,
      ST_FL_WB,
      ST_NT_WR,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/cmo_scan_ctr.sv
module cmo_scan_ctr #(
   parameter int LINES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     step,
   output logic [$clog2(LINES)-1:0] idx,
   output logic                     last
);
   localparam int IDX_W = $clog2(LINES);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (clear) idx_q <= '0;
      else if (step)  idx_q <= idx_q + 1'b1;
   end

   assign idx  = idx_q;
   assign last = (idx_q == IDX_W'(LINES - 1));

   // R3: the walk advances one index per step, in ascending order
   a_r3_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
      step && !clear |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

endmodule

// File: rtl/cmo_line_store.sv
module cmo_line_store #(
   parameter int LINES  = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wt_mode,
   input  logic                            fill_en,
   input  logic [$clog2(LINES)-1:0]        fill_idx,
   input  logic [ADDR_W-$clog2(LINES)-1:0] fill_tag,
   input  logic [DATA_W-1:0]               fill_data,
   input  logic                            fill_dirty,
   input  logic [$clog2(LINES)-1:0]        sel_idx,
   input  logic                            kill_en,
   input  logic                            clean_en,
   output logic                            sel_valid,
   output logic                            sel_dirty,
   output logic [ADDR_W-$clog2(LINES)-1:0] sel_tag,
   output logic [DATA_W-1:0]               sel_data,
   input  logic [$clog2(LINES)-1:0]        probe_idx,
   output logic                            probe_valid,
   output logic                            probe_dirty,
   output logic [ADDR_W-$clog2(LINES)-1:0] probe_tag,
   output logic [DATA_W-1:0]               probe_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   logic [LINES-1:0] v_vec;
   logic [LINES-1:0] d_vec;
   logic [TAG_W-1:0]  t_arr [LINES];
   logic [DATA_W-1:0] w_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic              v_r;
      logic              d_r;
      logic [TAG_W-1:0]  t_r;
      logic [DATA_W-1:0] w_r;
      logic              hit_sel;
      logic              hit_fill;

      assign hit_sel  = (sel_idx  == IDX_W'(i));
      assign hit_fill = (fill_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            d_r <= 1'b0;
         end else if (kill_en && hit_sel) begin
            v_r <= 1'b0;
            d_r <= 1'b0;
         end else if (clean_en && hit_sel) begin
            d_r <= 1'b0;
         end else if (fill_en && hit_fill) begin
            v_r <= 1'b1;
            d_r <= fill_dirty && !wt_mode;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_en && hit_fill) begin
            t_r <= fill_tag;
            w_r <= fill_data;
         end
      end

      assign v_vec[i] = v_r;
      assign d_vec[i] = d_r;
      assign t_arr[i] = t_r;
      assign w_arr[i] = w_r;

      // R3: a modified line is always a present line
      a_r3_dirty_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
         d_r |-> v_r);
   end

   assign sel_valid   = v_vec[sel_idx];
   assign sel_dirty   = d_vec[sel_idx];
   assign sel_tag     = t_arr[sel_idx];
   assign sel_data    = w_arr[sel_idx];
   assign probe_valid = v_vec[probe_idx];
   assign probe_dirty = d_vec[probe_idx];
   assign probe_tag   = t_arr[probe_idx];
   assign probe_data  = w_arr[probe_idx];

endmodule

// File: rtl/cmo_seq_ctrl.sv
module cmo_seq_ctrl
   import cmo_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sbc_two,
   input  logic                            cmd_valid,
   output logic                            cmd_ready,
   input  logic [1:0]                      cmd_op,
   input  logic [ADDR_W-1:0]               cmd_addr,
   input  logic [DATA_W-1:0]               cmd_data,
   input  logic                            mem_ready,
   output logic                            mem_valid,
   output logic [ADDR_W-1:0]               mem_addr,
   output logic [DATA_W-1:0]               mem_data,
   output logic                            sbc_valid,
   output logic [1:0]                      sbc_code,
   output logic                            done,
   input  logic [$clog2(LINES)-1:0]        scan_idx,
   input  logic                            scan_last,
   output logic                            scan_clear,
   output logic                            scan_step,
   output logic [$clog2(LINES)-1:0]        sel_idx,
   input  logic                            sel_valid,
   input  logic                            sel_dirty,
   input  logic [ADDR_W-$clog2(LINES)-1:0] sel_tag,
   input  logic [DATA_W-1:0]               sel_data,
   output logic                            kill_en,
   output logic                            clean_en
);
   localparam int IDX_W = $clog2(LINES);

   seq_state_e        state_q, state_d;
   cmo_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              two_q;
   logic              use_scan;
   logic              hit;
   logic              accept;

   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_ready && cmd_valid;
   assign sel_idx   = use_scan ? scan_idx : addr_q[IDX_W-1:0];
   assign hit       = sel_valid && (sel_tag == addr_q[ADDR_W-1:IDX_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_INV_ALL;
         addr_q  <= '0;
         data_q  <= '0;
         two_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_q   <= cmo_op_e'(cmd_op);
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            two_q  <= sbc_two;
         end
      end
   end

   always_comb begin
      state_d    = state_q;
      scan_clear = 1'b0;
      scan_step  = 1'b0;
      kill_en    = 1'b0;
      clean_en   = 1'b0;
      mem_valid  = 1'b0;
      mem_addr   = '0;
      mem_data   = '0;
      sbc_valid  = 1'b0;
      sbc_code   = SBC_NONE;
      done       = 1'b0;
      use_scan   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            scan_clear = 1'b1;
            if (cmd_valid) begin
               unique case (cmo_op_e'(cmd_op))
                  OP_INV_ALL:  state_d = ST_INV_SCAN;
                  OP_WB_INV:   state_d = ST_WB_SCAN;
                  OP_FLUSH:    state_d = ST_FL_LOOK;
                  OP_NT_STORE: state_d = ST_NT_WR;
                  default:     state_d = ST_IDLE;
               endcase
            end
         end
         ST_WB_SCAN: begin
            use_scan = 1'b1;
            if (sel_valid && sel_dirty) begin
               state_d = ST_WB_SEND;
            end else begin
               scan_step = 1'b1;
               if (scan_last) state_d = ST_INV_SCAN;
            end
         end
         ST_WB_SEND: begin
            use_scan  = 1'b1;
            mem_valid = 1'b1;
            mem_addr  = {sel_tag, scan_idx};
            mem_data  = sel_data;
            if (mem_ready) begin
               clean_en  = 1'b1;
               scan_step = 1'b1;
               state_d   = scan_last ? ST_INV_SCAN : ST_WB_SCAN;
            end
         end
         ST_INV_SCAN: begin
            use_scan  = 1'b1;
            kill_en   = 1'b1;
            scan_step = 1'b1;
            if (scan_last) state_d = ST_SBC_A;
         end
         ST_SBC_A: begin
            sbc_valid = 1'b1;
            if (op_q == OP_INV_ALL) begin
               sbc_code = SBC_INV;
               state_d  = ST_DONE;
            end else if (two_q) begin
               sbc_code = SBC_WBN;
               state_d  = ST_SBC_B;
            end else begin
               sbc_code = SBC_WBINV;
               state_d  = ST_DONE;
            end
         end
         ST_SBC_B: begin
            sbc_valid = 1'b1;
            sbc_code  = SBC_INV;
            state_d   = ST_DONE;
         end
         ST_FL_LOOK: begin
            if (hit && sel_dirty) begin
               state_d = ST_FL_WB;
            end else begin
               kill_en = hit;
               state_d = ST_DONE;
            end
         end
         ST_FL_WB: begin
            mem_valid = 1'b1;
            mem_addr  = addr_q;
            mem_data  = sel_data;
            if (mem_ready) begin
               kill_en = 1'b1;
               state_d = ST_DONE;
            end
         end
         ST_NT_WR: begin
            mem_valid = 1'b1;
            mem_addr  = addr_q;
            mem_data  = data_q;
            if (mem_ready) begin
               kill_en = hit;
               state_d = ST_DONE;
            end
         end
         ST_DONE: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // R5: a pending memory write keeps address and data until taken
   a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

   // R4: the writeback notice is always followed by the invalidate notice
   a_r4_notice_order: assert property (@(posedge clk) disable iff (!rst_n)
      sbc_valid && sbc_code == SBC_WBN |=> sbc_valid && sbc_code == SBC_INV);

   // R10: done follows the final notice and lasts one cycle
   a_r10_done_after_notice: assert property (@(posedge clk) disable iff (!rst_n)
      sbc_valid && sbc_code != SBC_WBN |=> done);
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !done && !mem_valid && !sbc_valid);

   // R2: invalidate-all never writes memory
   a_r2_no_write_on_inv: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready && op_q == OP_INV_ALL |-> !mem_valid);

   // R8: a flush miss completes in the next cycle with no traffic
   a_r8_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FL_LOOK && !hit |=> done && !mem_valid && !sbc_valid);

   // R3: only modified lines reach the memory port during the scan
   a_r3_only_dirty_sent: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_WB_SEND |-> sel_valid && sel_dirty);

endmodule

// File: rtl/cmo_sequencer.sv
module cmo_sequencer #(
   parameter int LINES  = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wt_mode,
   input  logic              sbc_two,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_data,
   input  logic              acc_dirty,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic              probe_dirty,
   output logic [DATA_W-1:0] probe_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              sbc_valid,
   output logic [1:0]        sbc_code,
   output logic              done
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0] scan_idx;
   logic             scan_last;
   logic             scan_clear;
   logic             scan_step;
   logic [IDX_W-1:0] sel_idx;
   logic             sel_valid;
   logic             sel_dirty;
   logic [TAG_W-1:0] sel_tag;
   logic [DATA_W-1:0] sel_data;
   logic             kill_en;
   logic             clean_en;
   logic             fill_en;
   logic             pr_valid;
   logic             pr_dirty;
   logic [TAG_W-1:0] pr_tag;

   assign acc_ready   = cmd_ready;
   assign fill_en     = acc_valid && acc_ready;
   assign probe_hit   = pr_valid && (pr_tag == probe_addr[ADDR_W-1:IDX_W]);
   assign probe_dirty = probe_hit && pr_dirty;

   cmo_scan_ctr #(.LINES(LINES)) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (scan_clear),
      .step  (scan_step),
      .idx   (scan_idx),
      .last  (scan_last)
   );

   cmo_line_store #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wt_mode     (wt_mode),
      .fill_en     (fill_en),
      .fill_idx    (acc_addr[IDX_W-1:0]),
      .fill_tag    (acc_addr[ADDR_W-1:IDX_W]),
      .fill_data   (acc_data),
      .fill_dirty  (acc_dirty),
      .sel_idx     (sel_idx),
      .kill_en     (kill_en),
      .clean_en    (clean_en),
      .sel_valid   (sel_valid),
      .sel_dirty   (sel_dirty),
      .sel_tag     (sel_tag),
      .sel_data    (sel_data),
      .probe_idx   (probe_addr[IDX_W-1:0]),
      .probe_valid (pr_valid),
      .probe_dirty (pr_dirty),
      .probe_tag   (pr_tag),
      .probe_data  (probe_data)
   );

   cmo_seq_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sbc_two    (sbc_two),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .cmd_data   (cmd_data),
      .mem_ready  (mem_ready),
      .mem_valid  (mem_valid),
      .mem_addr   (mem_addr),
      .mem_data   (mem_data),
      .sbc_valid  (sbc_valid),
      .sbc_code   (sbc_code),
      .done       (done),
      .scan_idx   (scan_idx),
      .scan_last  (scan_last),
      .scan_clear (scan_clear),
      .scan_step  (scan_step),
      .sel_idx    (sel_idx),
      .sel_valid  (sel_valid),
      .sel_dirty  (sel_dirty),
      .sel_tag    (sel_tag),
      .sel_data   (sel_data),
      .kill_en    (kill_en),
      .clean_en   (clean_en)
   );

endmodule

// File: tb/cmo_sequencer_test.sv
`timescale 1ns/1ps
module cmo_sequencer_test;
   localparam int LINES  = 8;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int IDX_W  = 3;
   localparam int TAG_W  = ADDR_W - IDX_W;

   logic clk = 0;
   logic rst_n = 0;
   logic wt_mode = 0, sbc_two = 0;
   logic cmd_valid = 0;
   logic cmd_ready;
   logic [1:0] cmd_op = 0;
   logic [ADDR_W-1:0] cmd_addr = 0;
   logic [DATA_W-1:0] cmd_data = 0;
   logic acc_valid = 0, acc_ready, acc_dirty = 0;
   logic [ADDR_W-1:0] acc_addr = 0;
   logic [DATA_W-1:0] acc_data = 0;
   logic [ADDR_W-1:0] probe_addr = 0;
   logic probe_hit, probe_dirty;
   logic [DATA_W-1:0] probe_data;
   logic mem_valid, mem_ready = 0;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_data;
   logic sbc_valid, done;
   logic [1:0] sbc_code;

   always #2 clk = ~clk;

   cmo_sequencer #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .sbc_two(sbc_two),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
      .acc_data(acc_data), .acc_dirty(acc_dirty),
      .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_dirty(probe_dirty),
      .probe_data(probe_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_data(mem_data), .sbc_valid(sbc_valid), .sbc_code(sbc_code), .done(done)
   );

   int checks = 0, errors = 0;
   int cyc = 0;
   bit finished = 0;
   bit rdy_always = 0;

   // shadow cache
   bit              sh_v [LINES];
   bit              sh_d [LINES];
   logic [TAG_W-1:0] sh_t [LINES];
   logic [DATA_W-1:0] sh_w [LINES];

   // observation log
   logic [ADDR_W-1:0] mon_a [64];
   logic [DATA_W-1:0] mon_d [64];
   int                mon_c [64];
   int                mon_n = 0;
   logic [1:0]        sbc_log [8];
   int                sbc_c [8];
   int                sbc_n = 0;
   bit                done_seen = 0;
   int                done_cnt = 0, done_cyc = 0, acc_cyc = 0;
   bit                rdy_at_done = 0, accr_at_done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always begin
      @(posedge clk);
      #1;
      mem_ready = rdy_always ? 1'b1 : ($urandom_range(0, 2) != 0);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_valid && mem_ready && mon_n < 64) begin
            mon_a[mon_n] = mem_addr;
            mon_d[mon_n] = mem_data;
            mon_c[mon_n] = cyc;
            mon_n++;
         end
         if (sbc_valid && sbc_n < 8) begin
            sbc_log[sbc_n] = sbc_code;
            sbc_c[sbc_n]   = cyc;
            sbc_n++;
         end
         if (done) begin
            done_seen    = 1;
            done_cnt++;
            done_cyc     = cyc;
            rdy_at_done  = cmd_ready;
            accr_at_done = acc_ready;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] mk_addr(input logic [TAG_W-1:0] t, input int i);
      return {t, i[IDX_W-1:0]};
   endfunction

   function automatic int inv_latency();
      return LINES + 2;
   endfunction

   task automatic fill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit dirty);
      int i;
      @(negedge clk);
      acc_valid = 1; acc_addr = a; acc_data = d; acc_dirty = dirty;
      @(negedge clk);
      acc_valid = 0;
      i = int'(a[IDX_W-1:0]);
      sh_v[i] = 1; sh_t[i] = a[ADDR_W-1:IDX_W]; sh_w[i] = d;
      sh_d[i] = dirty && !wt_mode;
   endtask

   task automatic random_fill(input int n);
      for (int k = 0; k < n; k++)
         fill(mk_addr(TAG_W'($urandom_range(0, 3)), $urandom_range(0, LINES - 1)),
              $urandom, $urandom_range(0, 1) == 1);
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input string req);
      int t;
      @(negedge clk);
      mon_n = 0; sbc_n = 0; done_seen = 0; done_cnt = 0;
      cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
      acc_cyc = cyc;
      @(negedge clk);
      cmd_valid = 0;
      t = 0;
      while (!done_seen && t < 5000) begin
         @(posedge clk);
         t++;
      end
      @(negedge clk);
      @(negedge clk);
      chk(done_seen, req, "done seen", 64'(done_seen), 64'd1);
      chk(done_cnt == 1, "R10", "done pulse count", 64'(done_cnt), 64'd1);
      chk(!rdy_at_done && !accr_at_done, "R10", "ready low at done",
          64'({rdy_at_done, accr_at_done}), 64'd0);
      chk(cmd_ready && acc_ready, "R10", "ready after done", 64'({cmd_ready, acc_ready}), 64'd3);
   endtask

   task automatic check_lines(input string req);
      for (int i = 0; i < LINES; i++) begin
         @(negedge clk);
         probe_addr = mk_addr(sh_t[i], i);
         #0.5;
         chk(probe_hit == sh_v[i], req, $sformatf("line %0d hit", i), 64'(probe_hit), 64'(sh_v[i]));
         if (sh_v[i]) begin
            chk(probe_dirty == sh_d[i], req, $sformatf("line %0d dirty", i),
                64'(probe_dirty), 64'(sh_d[i]));
            chk(probe_data == sh_w[i], req, $sformatf("line %0d data", i),
                64'(probe_data), 64'(sh_w[i]));
         end
      end
   endtask

   task automatic do_wbinv(input bit two, input string req);
      logic [ADDR_W-1:0] ea [LINES];
      logic [DATA_W-1:0] ed [LINES];
      int en = 0;
      for (int i = 0; i < LINES; i++)
         if (sh_v[i] && sh_d[i]) begin
            ea[en] = mk_addr(sh_t[i], i); ed[en] = sh_w[i]; en++;
         end
      sbc_two = two;
      run_cmd(2'b01, '0, '0, req);
      chk(mon_n == en, req, "writeback count", 64'(mon_n), 64'(en));
      for (int k = 0; k < en && k < mon_n; k++) begin
         chk(mon_a[k] == ea[k], "R3", $sformatf("writeback %0d addr", k), 64'(mon_a[k]), 64'(ea[k]));
         chk(mon_d[k] == ed[k], "R3", $sformatf("writeback %0d data", k), 64'(mon_d[k]), 64'(ed[k]));
      end
      if (mon_n > 0 && sbc_n > 0)
         chk(mon_c[mon_n-1] < sbc_c[0], "R3", "writes precede notice",
             64'(mon_c[mon_n-1]), 64'(sbc_c[0]));
      if (two) begin
         chk(sbc_n == 2, "R4", "two-cycle notice count", 64'(sbc_n), 64'd2);
         chk(sbc_log[0] == 2'b10 && sbc_log[1] == 2'b01, "R4", "two-cycle codes",
             64'({sbc_log[0], sbc_log[1]}), 64'h9);
         chk(sbc_c[1] == sbc_c[0] + 1, "R4", "notices adjacent", 64'(sbc_c[1]), 64'(sbc_c[0] + 1));
      end else begin
         chk(sbc_n == 1 && sbc_log[0] == 2'b11, "R4", "combined notice",
             64'({sbc_n[3:0], sbc_log[0]}), 64'h7);
      end
      if (sbc_n > 0)
         chk(done_cyc == sbc_c[sbc_n-1] + 1, "R10", "done after last notice",
             64'(done_cyc), 64'(sbc_c[sbc_n-1] + 1));
      for (int i = 0; i < LINES; i++) begin sh_v[i] = 0; sh_d[i] = 0; end
      check_lines("R3");
   endtask

   task automatic do_flush(input logic [ADDR_W-1:0] a);
      int i = int'(a[IDX_W-1:0]);
      bit hit = sh_v[i] && sh_t[i] == a[ADDR_W-1:IDX_W];
      bit dirty = hit && sh_d[i];
      logic [DATA_W-1:0] w = sh_w[i];
      run_cmd(2'b10, a, '0, "R7");
      chk(mon_n == (dirty ? 1 : 0), dirty ? "R7" : "R8", "flush write count",
          64'(mon_n), 64'(dirty));
      if (dirty && mon_n > 0) begin
         chk(mon_a[0] == a, "R7", "flush addr", 64'(mon_a[0]), 64'(a));
         chk(mon_d[0] == w, "R7", "flush data", 64'(mon_d[0]), 64'(w));
      end
      chk(sbc_n == 0, "R7", "flush no notice", 64'(sbc_n), 64'd0);
      if (!hit)
         chk(done_cyc - acc_cyc == 2, "R8", "miss latency", 64'(done_cyc - acc_cyc), 64'd2);
      if (hit) begin sh_v[i] = 0; sh_d[i] = 0; end
      check_lines(hit ? "R7" : "R8");
   endtask

   task automatic do_nt(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      int i = int'(a[IDX_W-1:0]);
      bit hit = sh_v[i] && sh_t[i] == a[ADDR_W-1:IDX_W];
      run_cmd(2'b11, a, d, "R9");
      chk(mon_n == 1, "R9", "nt write count", 64'(mon_n), 64'd1);
      chk(mon_a[0] == a && mon_d[0] == d, "R9", "nt write", 64'({mon_a[0], mon_d[0]}), 64'({a, d}));
      chk(sbc_n == 0, "R9", "nt no notice", 64'(sbc_n), 64'd0);
      if (hit) begin sh_v[i] = 0; sh_d[i] = 0; end
      @(negedge clk);
      probe_addr = a;
      #0.5;
      chk(!probe_hit, "R9", "nt no allocation", 64'(probe_hit), 64'd0);
      check_lines("R9");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < LINES; i++) begin sh_v[i] = 0; sh_d[i] = 0; sh_t[i] = '0; sh_w[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready && acc_ready, "R1", "ready after reset", 64'({cmd_ready, acc_ready}), 64'd3);
      chk(!mem_valid && !sbc_valid && !done, "R1", "outputs quiet",
          64'({mem_valid, sbc_valid, done}), 64'd0);
      check_lines("R1");

      // R2 invalidate-all drops dirty data
      random_fill(10);
      fill(mk_addr(9'd5, 2), 32'hDEAD_BEEF, 1);
      run_cmd(2'b00, '0, '0, "R2");
      chk(mon_n == 0, "R2", "no writeback", 64'(mon_n), 64'd0);
      chk(sbc_n == 1 && sbc_log[0] == 2'b01, "R2", "invalidate notice",
          64'({sbc_n[3:0], sbc_log[0]}), 64'h5);
      chk(done_cyc - acc_cyc == inv_latency(), "R2", "latency",
          64'(done_cyc - acc_cyc), 64'(inv_latency()));
      for (int i = 0; i < LINES; i++) begin sh_v[i] = 0; sh_d[i] = 0; end
      check_lines("R2");

      // R3/R4 all lines dirty, always-ready memory, both notice modes
      rdy_always = 1;
      for (int i = 0; i < LINES; i++) fill(mk_addr(TAG_W'(i + 1), i), $urandom, 1);
      do_wbinv(0, "R4");
      rdy_always = 0;
      random_fill(12);
      do_wbinv(1, "R4");
      // empty cache
      do_wbinv(0, "R3");

      // R6 write-through mode
      wt_mode = 1;
      random_fill(8);
      for (int i = 0; i < LINES; i++) fill(mk_addr(9'd7, i), $urandom, 1);
      check_lines("R6");
      do_wbinv(1, "R6");
      chk(mon_n == 0, "R6", "no writeback in write-through", 64'(mon_n), 64'd0);
      wt_mode = 0;

      // directed flush corners: dirty hit, clean hit, miss
      fill(mk_addr(9'd3, 4), 32'h1234_5678, 1);
      fill(mk_addr(9'd3, 5), 32'h0BAD_F00D, 0);
      fill(mk_addr(9'd2, 6), 32'h0000_0042, 1);
      do_flush(mk_addr(9'd3, 4));
      do_flush(mk_addr(9'd3, 5));
      do_flush(mk_addr(9'd1, 6));
      // nt store hit and miss
      do_nt(mk_addr(9'd2, 6), 32'hCAFE_0001);
      do_nt(mk_addr(9'd0, 1), 32'hCAFE_0002);

      // constrained random mix
      for (int it = 0; it < 40; it++) begin
         int sel = $urandom_range(0, 9);
         random_fill($urandom_range(1, 4));
         if (sel < 4) begin
            int i = $urandom_range(0, LINES - 1);
            do_flush(($urandom_range(0, 1) == 1 && sh_v[i]) ? mk_addr(sh_t[i], i)
                     : mk_addr(TAG_W'($urandom_range(0, 3)), i));
         end else if (sel < 8) begin
            do_nt(mk_addr(TAG_W'($urandom_range(0, 3)), $urandom_range(0, LINES - 1)), $urandom);
         end else begin
            do_wbinv($urandom_range(0, 1) == 1, "R3");
         end
      end

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule